// File: doc/BRIEF.md
# Maskable Latched Interrupt Aggregator

This block merges a set of hardware cause events and one software-raised request into a single level-style interrupt line. Each cause arrives as a one-cycle strobe and is captured in its own sticky status bit. The bit stays set until software acknowledges it by writing a 1 to that bit position in the status word. The interrupt line is high whenever any status bit is set, unless a global mask bit in the command word holds it low.

Software raises a request of its own by writing the trigger bit of the command word. That request is latched in the top status bit and behaves like any hardware cause. It is acknowledged in the same way, and it is held back by the mask in the same way. A cause that is latched while the mask is set stays pending. It drives the line as soon as the mask is written back to 0, and no other write is needed.

The register port is a single-cycle write port plus a combinational read of the selected word. Both words are NUM_SRC+1 bits wide.

Top module: `irq_aggregator`

## Requirements
- R1: A synchronous active-high reset clears every status bit, the mask and the interrupt output. The reset state reads back as 0 in both words.
- R2: A strobe on `ev_pulse[i]` sets status bit i at the next rising clock edge. The bit stays set with no further strobe, and `irq` is high when sampled after that edge, provided the mask is 0.
- R3: A write to the status word (`reg_addr`=1) clears each status bit whose data bit is 1. A status bit whose data bit is 0 keeps its value, so a write of all zeros changes nothing.
- R4: `irq` stays high as long as any status bit remains set and the mask is 0. It falls at the edge where the last set bit is acknowledged.
- R5: Writing the command word (`reg_addr`=0) copies data bit 0 into the mask. While the mask is 1, `irq` is low, but causes keep latching. When a later command write clears the mask, `irq` rises at that edge for any pending bit.
- R6: A command write with data bit 1 set raises the software request, which is status bit NUM_SRC. A command write with data bit 1 clear leaves that status bit unchanged.
- R7: Writing 1 to status bit NUM_SRC clears the software request. The line drops if no other bit is set.
- R8: A single command write that sets both the mask and the software trigger leaves `irq` low with the request pending. A later write that clears the mask raises `irq` without any new trigger.
- R9: If a strobe on a source and an acknowledge of that same bit occur in the same cycle, the bit stays set.
- R10: Reading the command word returns the mask in bit 0 and zeros in all other bits, including the trigger bit. Reading the status word returns the status bits with hardware source i at bit i and the software request at bit NUM_SRC.
- R11: `irq` comes from a register. After every edge outside reset, it equals the OR of the status bits ANDed with the inverse of the mask, as both stand after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_pulse | input | NUM_SRC | One-cycle cause strobes, one per hardware source |
| reg_wr | input | 1 | Write enable for the register port |
| reg_addr | input | 1 | Word select: 0 = command, 1 = status |
| reg_wdata | input | NUM_SRC+1 | Write data |
| reg_rdata | output | NUM_SRC+1 | Read data of the selected word |
| irq | output | 1 | Level interrupt output |

## Verification
The bench goes after several corner cases, each tied to a specific failure:
- A source strobe that coincides with its own acknowledge. A design that lets the clear win would lose that event.
- A status write whose zero bits must not disturb other pending causes. A design that treats the write as a plain load would drop unacknowledged causes and release the line early.
- A combined mask-and-trigger write, followed by a mask-only clear. A design that ignores pending state at unmask would never fire.
- A mask that fails to gate the output would show up as an early interrupt.
- Partial acknowledges while other bits remain set. These expose an output that follows only the newest cause.
- Reset applied while causes are pending.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    // Command word layout
    localparam int CMD_MASK_BIT = 0;
    localparam int CMD_SWI_BIT  = 1;

    typedef enum logic {
        REG_CMD    = 1'b0,
        REG_STATUS = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic swi_req;   // bit 1
        logic mask;      // bit 0
    } cmd_fields_t;

    function automatic cmd_fields_t unpack_cmd(input logic [1:0] bits);
        cmd_fields_t f;
        f.swi_req = bits[CMD_SWI_BIT];
        f.mask    = bits[CMD_MASK_BIT];
        return f;
    endfunction

endpackage

// File: rtl/irq_cmd_reg.sv
module irq_cmd_reg
    import irq_agg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_cmd,
    input  logic [1:0]  cmd_bits,
    output logic        mask_q,
    output logic        mask_next,
    output logic        swi_set
);
    cmd_fields_t fields;

    always_comb begin
        fields    = unpack_cmd(cmd_bits);
        mask_next = wr_cmd ? fields.mask : mask_q;
        swi_set   = wr_cmd & fields.swi_req;
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= 1'b0;
        else     mask_q <= mask_next;
    end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int WIDTH = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set_vec,
    input  logic [WIDTH-1:0] clr_vec,
    output logic [WIDTH-1:0] stat_q,
    output logic [WIDTH-1:0] stat_next
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        // set dominates clear in the same cycle
        assign stat_next[i] = set_vec[i] | (stat_q[i] & ~clr_vec[i]);

        always_ff @(posedge clk) begin
            if (rst) stat_q[i] <= 1'b0;
            else     stat_q[i] <= stat_next[i];
        end
    end
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
    parameter int WIDTH = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] stat_next,
    input  logic             mask_next,
    output logic             irq
);
    logic any_pending;

    assign any_pending = |stat_next;

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= any_pending & ~mask_next;
    end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SRC-1:0]   ev_pulse,
    input  logic                 reg_wr,
    input  logic                 reg_addr,
    input  logic [NUM_SRC:0]     reg_wdata,
    output logic [NUM_SRC:0]     reg_rdata,
    output logic                 irq
);
    localparam int STAT_W  = NUM_SRC + 1;
    localparam int SWI_POS = NUM_SRC;

    reg_sel_e            sel;
    logic                wr_cmd;
    logic                wr_stat;
    logic                mask_q;
    logic                mask_next;
    logic                swi_set;
    logic [STAT_W-1:0]   set_vec;
    logic [STAT_W-1:0]   clr_vec;
    logic [STAT_W-1:0]   stat_q;
    logic [STAT_W-1:0]   stat_next;

    assign sel     = reg_sel_e'(reg_addr);
    assign wr_cmd  = reg_wr && (sel == REG_CMD);
    assign wr_stat = reg_wr && (sel == REG_STATUS);

    irq_cmd_reg u_cmd (
        .clk       (clk),
        .rst       (rst),
        .wr_cmd    (wr_cmd),
        .cmd_bits  (reg_wdata[1:0]),
        .mask_q    (mask_q),
        .mask_next (mask_next),
        .swi_set   (swi_set)
    );

    always_comb begin
        set_vec              = '0;
        set_vec[NUM_SRC-1:0] = ev_pulse;
        set_vec[SWI_POS]     = swi_set;
        clr_vec              = wr_stat ? reg_wdata : '0;
    end

    irq_status_bank #(.WIDTH(STAT_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .set_vec   (set_vec),
        .clr_vec   (clr_vec),
        .stat_q    (stat_q),
        .stat_next (stat_next)
    );

    irq_out_stage #(.WIDTH(STAT_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .stat_next (stat_next),
        .mask_next (mask_next),
        .irq       (irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (sel == REG_STATUS) reg_rdata = stat_q;
        else                   reg_rdata[CMD_MASK_BIT] = mask_q;
    end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
    parameter int NUM_SRC = 6
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] ev_pulse,
    input logic               reg_wr,
    input logic               reg_addr,
    input logic [NUM_SRC:0]   reg_wdata,
    input logic               irq,
    input logic [NUM_SRC:0]   stat_q,
    input logic               mask_q
);
    logic [NUM_SRC:0] ack_vec;
    logic [NUM_SRC:0] set_vec;

    assign ack_vec = (reg_wr && reg_addr) ? reg_wdata : '0;
    assign set_vec = {(reg_wr && !reg_addr && reg_wdata[1]), ev_pulse};

    AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & $past(set_vec)) == $past(set_vec))); // R9

    AST_UNACKED_HOLD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & $past(stat_q & ~ack_vec)) == $past(stat_q & ~ack_vec))); // R3

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & $past(ack_vec & ~set_vec)) == '0)); // R3

    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(set_vec)) == '0)); // R2

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        mask_q |-> !irq); // R5

    AST_MASK_WRITE: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_addr) |=> (mask_q == $past(reg_wdata[0]))); // R5

    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (irq == ((|stat_q) && !mask_q))); // R11
endmodule

bind irq_aggregator irq_aggregator_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ev_pulse  (ev_pulse),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq       (irq),
    .stat_q    (stat_q),
    .mask_q    (mask_q)
);

// File: tb/irq_aggregator_tb.sv
`timescale 1ns/1ps
module irq_aggregator_tb;
    localparam int NS = 6;
    localparam int W  = NS + 1;

    logic          clk = 1'b0;
    logic          rst;
    logic [NS-1:0] ev_pulse;
    logic          reg_wr;
    logic          reg_addr;
    logic [W-1:0]  reg_wdata;
    logic [W-1:0]  reg_rdata;
    logic          irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    irq_aggregator #(.NUM_SRC(NS)) u_dut (
        .clk(clk), .rst(rst), .ev_pulse(ev_pulse), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    typedef struct packed {
        logic [NS-1:0] ev;
        logic          wr;
        logic          addr;
        logic [W-1:0]  wdata;
        logic [W-1:0]  exp_stat;
        logic          exp_irq;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{6'b000001, 1'b0, 1'b0, 7'h00, 7'b0000001, 1'b1},
        '{6'b000100, 1'b0, 1'b0, 7'h00, 7'b0000101, 1'b1},
        '{6'b000000, 1'b0, 1'b0, 7'h00, 7'b0000101, 1'b1},
        '{6'b000000, 1'b1, 1'b1, 7'h04, 7'b0000001, 1'b1},
        '{6'b000000, 1'b1, 1'b1, 7'h00, 7'b0000001, 1'b1},
        '{6'b000000, 1'b1, 1'b1, 7'h01, 7'b0000000, 1'b0},
        '{6'b000000, 1'b1, 1'b0, 7'h01, 7'b0000000, 1'b0},
        '{6'b100000, 1'b0, 1'b0, 7'h00, 7'b0100000, 1'b0},
        '{6'b000000, 1'b1, 1'b0, 7'h00, 7'b0100000, 1'b1},
        '{6'b000000, 1'b1, 1'b1, 7'h20, 7'b0000000, 1'b0},
        '{6'b000000, 1'b1, 1'b0, 7'h02, 7'b1000000, 1'b1},
        '{6'b000000, 1'b1, 1'b1, 7'h40, 7'b0000000, 1'b0},
        '{6'b000000, 1'b1, 1'b0, 7'h03, 7'b1000000, 1'b0},
        '{6'b000000, 1'b0, 1'b0, 7'h00, 7'b1000000, 1'b0},
        '{6'b000000, 1'b1, 1'b0, 7'h00, 7'b1000000, 1'b1},
        '{6'b000010, 1'b0, 1'b0, 7'h00, 7'b1000010, 1'b1},
        '{6'b000000, 1'b1, 1'b1, 7'h40, 7'b0000010, 1'b1},
        '{6'b000010, 1'b1, 1'b1, 7'h02, 7'b0000010, 1'b1},
        '{6'b000000, 1'b1, 1'b1, 7'h7F, 7'b0000000, 1'b0}
    };

    function automatic string req_of(input int idx);
        case (idx)
            0, 1, 2:   return "R2";
            3, 4:      return "R3";
            5, 16:     return "R4";
            6, 7, 8, 9: return "R5";
            10:        return "R6";
            11:        return "R7";
            12, 13, 14: return "R8";
            15:        return "R2";
            17:        return "R9";
            default:   return "R3";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        ev_pulse  = '0;
        reg_wr    = 1'b0;
        reg_addr  = 1'b1;
        reg_wdata = '0;
    endtask

    // drive at negedge, clock once, then read status between edges
    task automatic apply(input logic [NS-1:0] ev, input logic wr,
                         input logic addr, input logic [W-1:0] wd);
        @(negedge clk);
        ev_pulse  = ev;
        reg_wr    = wr;
        reg_addr  = addr;
        reg_wdata = wd;
        @(posedge clk);
        #1 idle();
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #100000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1", "irq", irq, 0);
        reg_addr = 1'b1; #0.5;
        check("R1", "status", reg_rdata, 0);
        reg_addr = 1'b0; #0.5;
        check("R1", "command", reg_rdata, 0);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].ev, VECS[i].wr, VECS[i].addr, VECS[i].wdata);
            check(req_of(i), "irq", irq, VECS[i].exp_irq);
            check(req_of(i), "status", reg_rdata, VECS[i].exp_stat);
        end

        // R10 / R6: command readback hides the trigger, shows the mask
        apply('0, 1'b1, 1'b0, 7'h03);
        reg_addr = 1'b0; #0.2;
        check("R10", "command read", reg_rdata, 7'h01);
        reg_addr = 1'b1; #0.2;
        check("R10", "status read", reg_rdata, 7'h40);
        check("R8", "irq masked", irq, 0);

        // R6: command write without trigger leaves software bit alone
        apply('0, 1'b1, 1'b0, 7'h00);
        check("R6", "status keeps swi", reg_rdata, 7'h40);
        check("R11", "irq after unmask", irq, 1);

        // R1: reset with pending causes clears everything
        apply(6'b111111, 1'b0, 1'b0, 7'h00);
        check("R2", "all sources latched", reg_rdata, 7'h7F);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1 rst = 1'b0;
        #1;
        check("R1", "irq after reset", irq, 0);
        check("R1", "status after reset", reg_rdata, 0);
        reg_addr = 1'b0; #0.2;
        check("R1", "mask after reset", reg_rdata, 0);

        finish_run();
    end
endmodule